// File: doc/BRIEF.md
# Up/Down Counter with Parallel Load and Decimal Mode

An 8-bit synchronous counter stepping one count per enabled clock edge, upward or downward as a direction input selects. A parallel load replaces the count with a data word, and an asynchronous active-low reset clears it. Counting happens only on edges where the enable input is high, so the counter runs on the single system clock and a slower rate comes from a periodic enable pulse instead of a derived clock.

A static parameter picks the arithmetic. In binary mode the whole word counts modulo 256. In decimal mode each 4-bit nibble holds one decimal digit, and digit carries and borrows ripple between nibbles, so the word counts 00 to 99 in packed BCD.

Top module: `rev_counter`

## Requirements
- R1: While rst_ni is low, count_o is 8'h00 at once, with no clock edge needed, and a load or count request on that edge has no effect; this zero is also the defined start-up value.
- R2: On a rising edge with load_i high, count_o takes data_i, whether en_i is high or low, and ahead of any count.
- R3: On a rising edge with en_i high, load_i low and up_i = 1, the count goes up by one step.
- R4: On a rising edge with en_i high, load_i low and up_i = 0, the count goes down by one step.
- R5: On a rising edge with en_i low and load_i low, count_o keeps its value.
- R6: In binary mode (DECIMAL = 0) the word counts modulo 256: up from 8'hFF gives 8'h00, down from 8'h00 gives 8'hFF, and up from 8'h09 gives 8'h0A.
- R7: In decimal mode (DECIMAL = 1), bits [3:0] are the units digit and bits [7:4] the tens digit. A units digit going from 9 to 0 adds one to the tens digit, and one going from 0 to 9 takes one from it (8'h09 up gives 8'h10, 8'h10 down gives 8'h09). After any count step each digit is 0 to 9.
- R8: In decimal mode, up from 8'h99 gives 8'h00 and down from 8'h00 gives 8'h99.
- R9: In decimal mode a loaded word with a digit above 9 is kept unchanged until the next count step.
- R10: In decimal mode, on a count step any digit above 9 first counts as 9, then the step applies (8'h3C up gives 8'h40, 8'h3C down gives 8'h38, 8'hF5 up gives 8'h96).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous parallel load |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| data_i | input | 8 | Load value |
| count_o | output | 8 | Current count |

## Verification
The count register drives the output directly, so any wrong state is visible on count_o one edge after the faulty step, with no latency to hide it. A broken digit carry or borrow stays invisible until the units digit crosses its 9/0 boundary. For that reason the bench starts from loaded values right at each boundary, and also from invalid digits, where a missing clamp shows up as a non-decimal nibble after a single step. A direction or enable fault shows up on the very next edge as a wrong value or a value that did not hold.

// File: rtl/rev_counter_pkg.sv
package rev_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } op_e;

  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;
endpackage

// File: rtl/rev_counter_ctrl.sv
module rev_counter_ctrl
  import rev_counter_pkg::*;
(
  input  logic load_i,
  input  logic en_i,
  output op_e  op_o
);
  // load wins over count
  always_comb begin
    if (load_i)    op_o = OP_LOAD;
    else if (en_i) op_o = OP_COUNT;
    else           op_o = OP_HOLD;
  end
endmodule

// File: rtl/rev_counter_digit.sv
module rev_counter_digit
  import rev_counter_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               up_i,
  input  logic               cin_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               cout_o
);
  localparam logic [DIGIT_W-1:0] MAX_D = DIGIT_W'(DIGIT_MAX);
  localparam logic [DIGIT_W-1:0] ONE_D = DIGIT_W'(1);

  logic [DIGIT_W-1:0] clamped;

  // non-decimal digit behaves as 9
  assign clamped = (digit_i > MAX_D) ? MAX_D : digit_i;

  always_comb begin
    digit_o = clamped;
    cout_o  = 1'b0;
    if (cin_i) begin
      if (up_i) begin
        if (clamped == MAX_D) begin
          digit_o = '0;
          cout_o  = 1'b1;
        end else begin
          digit_o = clamped + ONE_D;
        end
      end else begin
        if (clamped == '0) begin
          digit_o = MAX_D;
          cout_o  = 1'b1;
        end else begin
          digit_o = clamped - ONE_D;
        end
      end
    end
  end
endmodule

// File: rtl/rev_counter_next.sv
module rev_counter_next
  import rev_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam int unsigned NDIG = WIDTH / DIGIT_W;

  if (DECIMAL) begin : g_dec
    logic [NDIG:0] carry;
    assign carry[0] = 1'b1;
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
      rev_counter_digit i_digit (
        .digit_i (cur_i[d*DIGIT_W +: DIGIT_W]),
        .up_i    (up_i),
        .cin_i   (carry[d]),
        .digit_o (nxt_o[d*DIGIT_W +: DIGIT_W]),
        .cout_o  (carry[d+1])
      );
    end
    if (WIDTH > NDIG*DIGIT_W) begin : g_pad
      assign nxt_o[WIDTH-1:NDIG*DIGIT_W] = '0;
    end
  end else begin : g_bin
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    assign nxt_o = up_i ? cur_i + ONE : cur_i - ONE;
  end
endmodule

// File: rtl/rev_counter.sv
module rev_counter
  import rev_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o
);
  localparam int unsigned NDIG = WIDTH / DIGIT_W;

  op_e              op;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_nxt;

  rev_counter_ctrl i_ctrl (
    .load_i (load_i),
    .en_i   (en_i),
    .op_o   (op)
  );

  rev_counter_next #(
    .WIDTH   (WIDTH),
    .DECIMAL (DECIMAL)
  ) i_next (
    .cur_i (count_q),
    .up_i  (up_i),
    .nxt_o (count_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  count_q <= data_i;
        OP_COUNT: count_q <= count_nxt;
        default:  count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

  function automatic logic all_digits_ok(input logic [WIDTH-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < NDIG; d++) begin
      if (v[d*DIGIT_W +: DIGIT_W] > DIGIT_W'(DIGIT_MAX)) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  rst_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> count_q == '0);

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(data_i));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(count_q));

  if (DECIMAL) begin : g_dec_chk
    // R7
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i) |=> all_digits_ok(count_q));
  end else begin : g_bin_chk
    // R6
    bin_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i && up_i) |=> count_q == $past(count_q) + WIDTH'(1));
  end
endmodule

// File: tb/test_rev_counter.sv
module test_rev_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic       up = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] q_bin, q_dec;
  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rev_counter #(.WIDTH(8), .DECIMAL(1'b0)) i_rev_counter (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load), .up_i(up),
    .data_i(din), .count_o(q_bin)
  );

  rev_counter #(.WIDTH(8), .DECIMAL(1'b1)) i_rev_counter_dec (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load), .up_i(up),
    .data_i(din), .count_o(q_dec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic e, input logic u, input logic [7:0] d);
    @(negedge clk);
    load = l; en = e; up = u; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  task automatic t_reset();
    #5;
    check("R1 start bin", q_bin, 8'h00);
    check("R1 start dec", q_dec, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 8'h55);
    check("R2 load 55", q_bin, 8'h55);
    @(negedge clk);
    #3; rst_n = 1'b0; #1;
    check("R1 async clear", q_bin, 8'h00);
    load = 1'b1; en = 1'b1; din = 8'h77;
    @(posedge clk); #1;
    check("R1 load blocked", q_bin, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_bin();
    drive(1'b1, 1'b0, 1'b1, 8'hFE);
    check("R2 load no en", q_bin, 8'hFE);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R3 up", q_bin, 8'hFF);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R6 wrap up", q_bin, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R3 up again", q_bin, 8'h01);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R4 down", q_bin, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 wrap down", q_bin, 8'hFF);
    drive(1'b0, 1'b0, 1'b1, 8'h12);
    check("R5 hold 1", q_bin, 8'hFF);
    drive(1'b0, 1'b0, 1'b0, 8'h34);
    check("R5 hold 2", q_bin, 8'hFF);
    drive(1'b1, 1'b1, 1'b1, 8'h40);
    check("R2 load over count", q_bin, 8'h40);
  endtask

  task automatic t_dec();
    drive(1'b1, 1'b0, 1'b1, 8'h98);
    check("R2 dec load", q_dec, 8'h98);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R3 dec up", q_dec, 8'h99);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R8 dec wrap up", q_dec, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 dec wrap down", q_dec, 8'h99);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R4 dec down", q_dec, 8'h98);
    drive(1'b1, 1'b0, 1'b1, 8'h09);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R7 carry", q_dec, 8'h10);
    check("R6 bin 09 up", q_bin, 8'h0A);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R7 borrow", q_dec, 8'h09);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 dec hold", q_dec, 8'h09);
  endtask

  task automatic t_invalid();
    drive(1'b1, 1'b0, 1'b1, 8'h3C);
    check("R9 kept 3C", q_dec, 8'h3C);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R10 3C up", q_dec, 8'h40);
    drive(1'b1, 1'b0, 1'b0, 8'h3C);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    check("R10 3C down", q_dec, 8'h38);
    drive(1'b1, 1'b0, 1'b1, 8'hF5);
    drive(1'b0, 1'b1, 1'b1, 8'h00);
    check("R10 F5 up", q_dec, 8'h96);
    drive(1'b1, 1'b0, 1'b1, 8'hAB);
    drive(1'b0, 1'b0, 1'b1, 8'h00);
    check("R9 kept AB", q_dec, 8'hAB);
  endtask

  initial begin
    t_reset();
    t_bin();
    t_dec();
    t_invalid();
    report();
  end

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule